// File: doc/BRIEF.md
# Lockstep Dual Counter with Shared Period Clear

This block holds two counters that advance together as one pair. It is meant for PWM generators where two channels must share a single time base. One run bit starts and stops both counters. The count strobe is taken from one of several source inputs, using the source and edge chosen in the first channel's control register. The second channel has a clock-control field of its own, but the block never uses it while the two channels run as a pair.

A period register can be chosen as the clear source. When the first counter equals the period on a count strobe, both counters return to zero on that same edge. Each channel keeps sticky wrap-up and wrap-down status bits. A clear that lands on the same strobe as a wrap always wins, so no status bit is raised. Software uses a small register port: writes are synchronous, and reads are combinational with a read strobe. While the pair is stopped, writes to a counter or to the period land at once. While the pair runs, such writes wait for the next count strobe.

Top module: `pair_timer`

## Requirements
- R1: After a synchronous reset, both counters and all status bits read 0, control reads 0, and the period register reads all ones.
- R2: With the run bit (address 0, bit 0) at 0, strobes change neither counter, and clearing the run bit freezes both counters with their status bits unchanged. With it at 1, both counters change on the same strobe.
- R3: Counting follows the source select (address 0, bits 5:4) and edge code (address 0, bits 7:6: 0 rising, 1 falling, 2 both) of channel 0. Channel 1's own clock field (address 1) and strobes on unselected sources have no effect.
- R4: With clear-select (address 0, bit 2 is direction, bit 1 is clear-select) set, a strobe that finds counter 0 (address 2) equal to the period (address 4) sets both counter 0 and counter 1 (address 3) to 0 on that edge.
- R5: With the period at all ones and clear-select set, the counters reach all ones and then return to 0 with no status bit set on either channel.
- R6: Counting up without a coinciding clear, a channel that wraps from all ones to 0 sets bit 0 of its status register (address 5 for channel 0, address 6 for channel 1).
- R7: With direction (bit 2) at 1, the counters count down, and a wrap from 0 to all ones sets status bit 1. A clear that coincides with that wrap leaves bit 1 at 0 and the counter at 0.
- R8: A status bit clears only when 0 is written to it and the previous access to that status register was a read (read strobe with the address) that returned the bit as 1. Writing 1, or writing 0 without that read, has no effect.
- R9: Counter and period writes take effect on the next edge while stopped. While running, they are held and loaded on the next count strobe.
- R10: Status bits are sticky and stay set through later counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_lvl | input | 4 | Clock-source levels, one per selectable source |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | W | Register write data |
| rd_en | input | 1 | Register read strobe (arms status clearing) |
| rd_addr | input | 3 | Register read address |
| rd_data | output | W | Combinational read data |

## Verification
The assertions assume that the source levels are low out of reset. They also assume that a source select or edge code changes only while the selected level is low, so that a mode change never produces a false edge. The stimulus keeps to both rules. It returns every source to low at the end of each tick, and it rewrites the control register only between ticks. Counter and period writes in the clear-precedence tests are made with the pair stopped, so no held load hides the clear being observed.

// File: rtl/pt_pkg.sv
package pt_pkg;
  localparam int AW    = 3;
  localparam int SRC_W = 2;
  localparam int NSRC  = 1 << SRC_W;
  localparam int CW    = 8;

  localparam logic [AW-1:0] A_CTRL0 = 3'd0;
  localparam logic [AW-1:0] A_CLK1  = 3'd1;
  localparam logic [AW-1:0] A_CNT0  = 3'd2;
  localparam logic [AW-1:0] A_CNT1  = 3'd3;
  localparam logic [AW-1:0] A_PER   = 3'd4;
  localparam logic [AW-1:0] A_STAT0 = 3'd5;
  localparam logic [AW-1:0] A_STAT1 = 3'd6;

  typedef enum logic [1:0] {
    EDGE_RISE = 2'd0,
    EDGE_FALL = 2'd1,
    EDGE_BOTH = 2'd2,
    EDGE_ALT  = 2'd3
  } edge_e;

  // Returns 1 when the transition prev->now matches the edge mode.
  function automatic logic edge_hit(edge_e mode, logic now_v, logic prev_v);
    logic rise, fall;
    rise = now_v & ~prev_v;
    fall = ~now_v & prev_v;
    case (mode)
      EDGE_FALL: edge_hit = fall;
      EDGE_BOTH: edge_hit = rise | fall;
      default:   edge_hit = rise;
    endcase
  endfunction
endpackage

// File: rtl/pt_edge_sel.sv
module pt_edge_sel
  import pt_pkg::*;
#(
  parameter int N = NSRC
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N-1:0]       src_lvl,
  input  logic [SRC_W-1:0]   sel,
  input  edge_e              mode,
  output logic               stb
);
  logic sel_lvl;
  logic prev_q;

  assign sel_lvl = src_lvl[sel];

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= sel_lvl;
  end

  assign stb = edge_hit(mode, sel_lvl, prev_q);
endmodule

// File: rtl/pt_counter.sv
module pt_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         run,
  input  logic         stb,
  input  logic         dir_dn,
  input  logic         clr,
  input  logic         wr_hit,
  input  logic [W-1:0] wr_val,
  output logic [W-1:0] cnt,
  output logic         pend,
  output logic         ovf_ev,
  output logic         unf_ev
);
  localparam logic [W-1:0] TOP = {W{1'b1}};

  function automatic logic [W-1:0] step(logic [W-1:0] v, logic dn);
    step = dn ? v - 1'b1 : v + 1'b1;
  endfunction

  function automatic logic at_edge(logic [W-1:0] v, logic dn);
    at_edge = dn ? (v == '0) : (v == TOP);
  endfunction

  logic [W-1:0] cnt_q, held_q;
  logic         held_v_q;
  logic         adv;
  logic         wrap;

  assign adv  = run & stb;
  assign wrap = adv & ~held_v_q & ~clr & at_edge(cnt_q, dir_dn);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q    <= '0;
      held_q   <= '0;
      held_v_q <= 1'b0;
    end else if (wr_hit && !run) begin
      cnt_q    <= wr_val;
      held_v_q <= 1'b0;
    end else begin
      if (adv) begin
        if (held_v_q)  cnt_q <= held_q;
        else if (clr)  cnt_q <= '0;
        else           cnt_q <= step(cnt_q, dir_dn);
      end
      if (wr_hit) begin
        held_q   <= wr_val;
        held_v_q <= 1'b1;
      end else if (adv) begin
        held_v_q <= 1'b0;
      end
    end
  end

  assign cnt    = cnt_q;
  assign pend   = held_v_q;
  assign ovf_ev = wrap & ~dir_dn;
  assign unf_ev = wrap & dir_dn;
endmodule

// File: rtl/pt_shadow.sv
module pt_shadow #(
  parameter int          W       = 16,
  parameter logic [W-1:0] RST_VAL = {W{1'b1}}
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         run,
  input  logic         stb,
  input  logic         wr_hit,
  input  logic [W-1:0] wr_val,
  output logic [W-1:0] val
);
  logic [W-1:0] val_q, held_q;
  logic         held_v_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      val_q    <= RST_VAL;
      held_q   <= RST_VAL;
      held_v_q <= 1'b0;
    end else if (wr_hit && !run) begin
      val_q    <= wr_val;
      held_v_q <= 1'b0;
    end else begin
      if (run && stb && held_v_q) val_q <= held_q;
      if (wr_hit) begin
        held_q   <= wr_val;
        held_v_q <= 1'b1;
      end else if (run && stb) begin
        held_v_q <= 1'b0;
      end
    end
  end

  assign val = val_q;
endmodule

// File: rtl/pt_flags.sv
module pt_flags (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] set_ev,
  input  logic       rd_hit,
  input  logic       wr_hit,
  input  logic [1:0] wr_bits,
  output logic [1:0] flags
);
  logic [1:0] flag_q, armed_q, drop;

  // A bit drops only when armed by a read that saw it set and written 0.
  assign drop = wr_hit ? (armed_q & ~wr_bits) : 2'b00;

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q  <= 2'b00;
      armed_q <= 2'b00;
    end else begin
      flag_q <= (flag_q & ~drop) | set_ev;
      if (wr_hit)      armed_q <= 2'b00;
      else if (rd_hit) armed_q <= flag_q;
    end
  end

  assign flags = flag_q;
endmodule

// File: rtl/pair_timer.sv
module pair_timer
  import pt_pkg::*;
#(
  parameter int W = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NSRC-1:0] src_lvl,
  input  logic           wr_en,
  input  logic [AW-1:0]  wr_addr,
  input  logic [W-1:0]   wr_data,
  input  logic           rd_en,
  input  logic [AW-1:0]  rd_addr,
  output logic [W-1:0]   rd_data
);
  localparam int NCH = 2;

  logic [CW-1:0] ctrl0_q, clk1_q;
  logic          run, clr_sel, dir_dn;
  logic          cnt_stb;
  logic          match_clr;
  logic [W-1:0]  period;
  logic [W-1:0]  cnt     [NCH];
  logic [NCH-1:0] pend_v, ovf_ev, unf_ev;
  logic [1:0]    stat    [NCH];
  logic [W-1:0]  cnt0, cnt1;
  logic [1:0]    stat0, stat1;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl0_q <= '0;
      clk1_q  <= '0;
    end else if (wr_en) begin
      if (wr_addr == A_CTRL0) ctrl0_q <= wr_data[CW-1:0];
      if (wr_addr == A_CLK1)  clk1_q  <= wr_data[CW-1:0];
    end
  end

  assign run     = ctrl0_q[0];
  assign clr_sel = ctrl0_q[1];
  assign dir_dn  = ctrl0_q[2];

  // Both channels use channel 0's source and edge.
  pt_edge_sel #(.N(NSRC)) u_edge (
    .clk     (clk),
    .rst     (rst),
    .src_lvl (src_lvl),
    .sel     (ctrl0_q[5:4]),
    .mode    (edge_e'(ctrl0_q[7:6])),
    .stb     (cnt_stb)
  );

  pt_shadow #(.W(W), .RST_VAL({W{1'b1}})) u_period (
    .clk    (clk),
    .rst    (rst),
    .run    (run),
    .stb    (cnt_stb),
    .wr_hit (wr_en && wr_addr == A_PER),
    .wr_val (wr_data),
    .val    (period)
  );

  assign match_clr = clr_sel & run & cnt_stb & (cnt[0] == period);

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    localparam logic [AW-1:0] CNT_A  = (g == 0) ? A_CNT0  : A_CNT1;
    localparam logic [AW-1:0] STAT_A = (g == 0) ? A_STAT0 : A_STAT1;

    pt_counter #(.W(W)) u_cnt (
      .clk    (clk),
      .rst    (rst),
      .run    (run),
      .stb    (cnt_stb),
      .dir_dn (dir_dn),
      .clr    (match_clr),
      .wr_hit (wr_en && wr_addr == CNT_A),
      .wr_val (wr_data),
      .cnt    (cnt[g]),
      .pend   (pend_v[g]),
      .ovf_ev (ovf_ev[g]),
      .unf_ev (unf_ev[g])
    );

    pt_flags u_flags (
      .clk     (clk),
      .rst     (rst),
      .set_ev  ({unf_ev[g], ovf_ev[g]}),
      .rd_hit  (rd_en && rd_addr == STAT_A),
      .wr_hit  (wr_en && wr_addr == STAT_A),
      .wr_bits (wr_data[1:0]),
      .flags   (stat[g])
    );
  end

  assign cnt0  = cnt[0];
  assign cnt1  = cnt[1];
  assign stat0 = stat[0];
  assign stat1 = stat[1];

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      A_CTRL0: rd_data[CW-1:0] = ctrl0_q;
      A_CLK1:  rd_data[CW-1:0] = clk1_q;
      A_CNT0:  rd_data = cnt0;
      A_CNT1:  rd_data = cnt1;
      A_PER:   rd_data = period;
      A_STAT0: rd_data[1:0] = stat0;
      A_STAT1: rd_data[1:0] = stat1;
      default: rd_data = '0;
    endcase
  end
endmodule

// File: rtl/pair_timer_chk.sv
module pair_timer_chk
  import pt_pkg::*;
#(
  parameter int W = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          run,
  input logic          dir_dn,
  input logic          cnt_stb,
  input logic          match_clr,
  input logic [1:0]    pend_v,
  input logic [1:0]    ovf_ev,
  input logic [W-1:0]  cnt0,
  input logic [W-1:0]  cnt1,
  input logic [1:0]    stat0,
  input logic          wr_en,
  input logic [AW-1:0] wr_addr
);
  // R2
  frozen_chk: assert property (@(posedge clk) disable iff (rst)
    (!run && !wr_en) |=> ($stable(cnt0) && $stable(cnt1)));

  // R2
  lockstep_step_chk: assert property (@(posedge clk) disable iff (rst)
    (run && cnt_stb && !match_clr && pend_v == 2'b00 && !dir_dn && cnt0 != {W{1'b1}})
      |=> (cnt0 == W'($past(cnt0) + 1'b1)));

  // R4
  pair_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (match_clr && pend_v == 2'b00) |=> (cnt0 == '0 && cnt1 == '0));

  // R5
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    (match_clr && !stat0[0] && !wr_en) |=> !stat0[0]);

  // R6
  overflow_flag_chk: assert property (@(posedge clk) disable iff (rst)
    ovf_ev[0] |=> stat0[0]);

  // R10
  sticky_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (stat0[0] && !(wr_en && wr_addr == A_STAT0)) |=> stat0[0]);
endmodule

bind pair_timer pair_timer_chk #(.W(W)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .run       (run),
  .dir_dn    (dir_dn),
  .cnt_stb   (cnt_stb),
  .match_clr (match_clr),
  .pend_v    (pend_v),
  .ovf_ev    (ovf_ev),
  .cnt0      (cnt0),
  .cnt1      (cnt1),
  .stat0     (stat0),
  .wr_en     (wr_en),
  .wr_addr   (wr_addr)
);

// File: tb/pair_timer_tb_top.sv
`timescale 1ns/1ps
module pair_timer_tb_top;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [3:0]   src_lvl = '0;
  logic         wr_en = 1'b0;
  logic [2:0]   wr_addr = '0;
  logic [W-1:0] wr_data = '0;
  logic         rd_en = 1'b0;
  logic [2:0]   rd_addr = '0;
  logic [W-1:0] rd_data;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  typedef struct {
    logic [W-1:0] exp;
    string        tag;
  } item_t;
  item_t sb_q[$];

  always #2.5 clk = ~clk;

  pair_timer #(.W(W)) dut_i (
    .clk(clk), .rst(rst), .src_lvl(src_lvl),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  // Monitor: samples read data mid-cycle and compares against the scoreboard.
  always @(negedge clk) begin
    #1;
    if (rd_en) begin
      if (sb_q.size() == 0) begin
        failures++;
        $display("FAIL monitor: read with empty scoreboard, actual %h expected none", rd_data);
      end else begin
        item_t it;
        it = sb_q.pop_front();
        checks++;
        if (rd_data !== it.exp) begin
          failures++;
          $display("FAIL %s: actual %h expected %h", it.tag, rd_data, it.exp);
        end
      end
    end
  end

  task automatic wr(input logic [2:0] a, input logic [W-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [W-1:0] e, input string tag);
    item_t it;
    @(negedge clk);
    it.exp = e; it.tag = tag;
    sb_q.push_back(it);
    rd_en = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic tick(input int s, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); src_lvl[s] = 1'b1;
      @(negedge clk); src_lvl[s] = 1'b0;
    end
  endtask

  initial begin
    #(200000 * 5);
    failures++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    rd(3'd0, 16'h0000, "R1 ctrl");
    rd(3'd2, 16'h0000, "R1 cnt0");
    rd(3'd3, 16'h0000, "R1 cnt1");
    rd(3'd4, 16'hFFFF, "R1 period");
    rd(3'd5, 16'h0000, "R1 stat0");
    rd(3'd6, 16'h0000, "R1 stat1");
    // R2 stopped: strobes ignored
    tick(0, 3);
    rd(3'd2, 16'h0000, "R2 stopped cnt0");
    // R2 run: both advance together
    wr(3'd0, 16'h0001);
    tick(0, 5);
    rd(3'd2, 16'h0005, "R2 run cnt0");
    rd(3'd3, 16'h0005, "R2 run cnt1");
    // R3 unselected source and channel 1 clock field ignored
    tick(1, 2);
    wr(3'd1, 16'h0010);
    tick(1, 2);
    rd(3'd3, 16'h0005, "R3 ch1 own clock ignored");
    tick(0, 1);
    rd(3'd3, 16'h0006, "R3 ch1 follows ch0");
    wr(3'd0, 16'h0041);
    tick(0, 1);
    rd(3'd2, 16'h0007, "R3 falling edge");
    wr(3'd0, 16'h0081);
    tick(0, 1);
    rd(3'd2, 16'h0009, "R3 both edges");
    // R2 stop freezes
    wr(3'd0, 16'h0000);
    tick(0, 2);
    rd(3'd2, 16'h0009, "R2 frozen");
    // R9 immediate writes while stopped; R6 overflow
    wr(3'd2, 16'hFFFD);
    wr(3'd3, 16'h0100);
    rd(3'd2, 16'hFFFD, "R9 stopped write");
    wr(3'd0, 16'h0001);
    tick(0, 3);
    rd(3'd2, 16'h0000, "R6 wrap cnt0");
    rd(3'd3, 16'h0103, "R6 cnt1");
    rd(3'd6, 16'h0000, "R6 no ovf ch1");
    tick(0, 2);
    // R10 / R8 flag protocol
    rd(3'd5, 16'h0001, "R10 sticky ovf");
    wr(3'd5, 16'h0001);
    wr(3'd5, 16'h0000);
    rd(3'd5, 16'h0001, "R8 unarmed write");
    wr(3'd5, 16'h0000);
    rd(3'd5, 16'h0000, "R8 armed clear");
    // R5 period all ones with clear
    wr(3'd0, 16'h0000);
    wr(3'd2, 16'hFFFD);
    wr(3'd3, 16'hFFFD);
    wr(3'd0, 16'h0003);
    tick(0, 2);
    rd(3'd2, 16'hFFFF, "R5 reach top");
    tick(0, 1);
    rd(3'd2, 16'h0000, "R5 cnt0 cleared");
    rd(3'd3, 16'h0000, "R5 cnt1 cleared");
    rd(3'd5, 16'h0000, "R5 no ovf ch0");
    rd(3'd6, 16'h0000, "R5 no ovf ch1");
    // R4 shorter period
    wr(3'd0, 16'h0000);
    wr(3'd2, 16'h0000);
    wr(3'd3, 16'h0020);
    wr(3'd4, 16'h0004);
    wr(3'd0, 16'h0003);
    tick(0, 4);
    rd(3'd3, 16'h0024, "R4 before match");
    tick(0, 1);
    rd(3'd2, 16'h0000, "R4 cnt0 clear");
    rd(3'd3, 16'h0000, "R4 cnt1 clear");
    // R7 counting down
    wr(3'd0, 16'h0000);
    wr(3'd2, 16'h0001);
    wr(3'd4, 16'hFFFF);
    wr(3'd0, 16'h0005);
    tick(0, 1);
    rd(3'd3, 16'hFFFF, "R7 cnt1 down wrap");
    rd(3'd6, 16'h0002, "R7 unf ch1");
    rd(3'd5, 16'h0000, "R7 no unf ch0 yet");
    tick(0, 1);
    rd(3'd5, 16'h0002, "R7 unf ch0");
    // R7 clear beats underflow
    wr(3'd0, 16'h0000);
    wr(3'd5, 16'h0000);
    rd(3'd6, 16'h0002, "R8 armed read ch1");
    wr(3'd6, 16'h0000);
    wr(3'd2, 16'h0000);
    wr(3'd3, 16'h0000);
    wr(3'd4, 16'h0000);
    wr(3'd0, 16'h0007);
    tick(0, 1);
    rd(3'd3, 16'h0000, "R7 clear wins cnt1");
    rd(3'd6, 16'h0000, "R7 no unf ch1");
    // R9 write while running held to next strobe
    wr(3'd0, 16'h0000);
    wr(3'd4, 16'hFFFF);
    wr(3'd0, 16'h0001);
    wr(3'd2, 16'h0050);
    rd(3'd2, 16'h0000, "R9 held before strobe");
    tick(0, 1);
    rd(3'd2, 16'h0050, "R9 loaded on strobe");
    rd(3'd3, 16'h0001, "R9 cnt1 counts");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule